// File: doc/BRIEF.md
# Lockable Chip-Select Mode Controller

This block serves a small expansion bus with a set of chip-select channels, four by default. Every channel owns an 8-bit mode register. Software programs the register through a simple write and read port. The register sets the polarity of the channel's select line, when the select is asserted within a transaction, and how the two shared strobe lines behave. It also holds a flag that records a bus write to the channel. When that flag is enabled, it raises a management interrupt request.

A channel's configuration can be frozen by a sticky lock bit. Once the lock is set, register writes no longer change any configuration bit of that channel, and they cannot clear the lock itself. The lock is removed only by reset or by an external unlock pulse. The write-detect flag is the single exemption: software can still clear it while the channel is locked.

The block does no address decoding. It receives the target channel number, an active phase, a strobe phase and a direction for each bus transaction. From these it drives the per-channel selects and the two strobe lines.

Top module: `xcs_mode_ctrl`

## Requirements
- R1: After reset:
  - every mode register reads 0x00;
  - every chip select is high;
  - both strobe lines are high;
  - the interrupt request is low.
- R2: A register write to an unlocked channel stores data bits 5:1 into those bits. Bit 0 always reads 0.
- R3: Bit 7 is the lock.
  - Writing 1 to bit 7 sets it. Writing 0 to bit 7 never clears it.
  - While the lock is 1, writes leave bits 7 and 5:1 unchanged.
- R4: A one-cycle pulse on `unlock_i` clears the lock of every channel. The channel's bits 5:1 become writable again.
- R5: Bit 6 is the write-detect flag.
  - It is set one clock after a cycle in which `bus_active_i`, `bus_write_i` and `bus_strobe_i` are all 1 and `bus_ch_i` selects the channel.
  - Writing 1 to bit 6 clears it, even while the channel is locked.
  - If a clear and a set fall in the same cycle, the flag ends at 1.
- R6: `smi_req_o` is 1 exactly while at least one channel has both bit 6 and bit 5 at 1. In the default build it follows the flags combinationally.
- R7: Bit 4 sets the select polarity.
  - With bit 4 at 0, the select idles at 1 and is driven to 0 when asserted.
  - With bit 4 at 1, the select idles at 0 and is driven to 1 when asserted.
  - Unselected channels sit at their idle level.
- R8: Bits 3:2 set the select timing.
  - Bit 2 at 1 limits the select during reads to cycles with `bus_strobe_i` at 1.
  - Bit 3 at 1 does the same for writes.
  - A timing bit at 0 asserts the select for the whole active phase.
- R9: With bit 1 at 1, bits 3:2 act as 00. The select then covers the whole active phase for both directions.
- R10: Mode 0 (bit 1 = 0) applies to the channel on `bus_ch_i`.
  - `wr_line_o` is low exactly during an active, strobed write.
  - `rd_line_o` is low exactly during an active, strobed read.
- R11: Mode 1 (bit 1 = 1) applies to the channel on `bus_ch_i`.
  - `wr_line_o` is low during an active write and high otherwise.
  - `rd_line_o` is high exactly when the phase is both active and strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unlock_i | input | 1 | Pulse that clears all lock bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | CH_W | Channel addressed for register write and readback |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Mode register of the addressed channel |
| bus_ch_i | input | CH_W | Channel targeted by the bus transaction |
| bus_active_i | input | 1 | Transaction active phase |
| bus_write_i | input | 1 | 1 for a write transaction, 0 for a read |
| bus_strobe_i | input | 1 | Strobe phase within the active phase |
| cs_o | output | NUM_CH | Per-channel chip selects |
| wr_line_o | output | 1 | Write strobe or direction line |
| rd_line_o | output | 1 | Read strobe or enable line |
| smi_req_o | output | 1 | Management interrupt request |

## Verification
The bench builds the block with NUM_CH = 4 and SMI_REG = 0. This keeps the interrupt request combinational, so it can be sampled in the cycle after a write hit. Four channels let one channel stay locked while neighbouring channels are reprogrammed, and let a polarity-inverted select be checked next to idle active-low ones. It also exercises the top channel index, where the readback and line-mode multiplexers end.

// File: rtl/xcs_mode_pkg.sv
package xcs_mode_pkg;

   localparam int MR_W = 8;

   // Field positions of the mode register (bit 0 reserved)
   localparam int B_LOCK  = 7;
   localparam int B_STAT  = 6;
   localparam int B_SMIEN = 5;
   localparam int B_POL   = 4;
   localparam int B_TRD   = 2;
   localparam int B_TWR   = 3;
   localparam int B_MODE  = 1;

   typedef struct packed {
      logic       lock;
      logic       stat;
      logic       smi_en;
      logic       pol;
      logic [1:0] tim;     // [1] write strobe-timed, [0] read strobe-timed
      logic       mode;
   } xcs_cfg_t;

   function automatic logic [MR_W-1:0] cfg_to_byte(xcs_cfg_t c);
      return {c, 1'b0};
   endfunction

endpackage

// File: rtl/xcs_mode_reg.sv
module xcs_mode_reg
   import xcs_mode_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            unlock_i,
   input  logic            wr_en_i,
   input  logic [MR_W-1:0] wdata_i,
   input  logic            hit_i,
   output xcs_cfg_t        cfg_o,
   output logic [MR_W-1:0] rdata_o
);

   xcs_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         // lock: set-only by software, cleared by unlock pulse
         if (unlock_i)
            cfg_q.lock <= 1'b0;
         else if (wr_en_i && wdata_i[B_LOCK])
            cfg_q.lock <= 1'b1;

         // configuration fields, frozen by the lock
         if (wr_en_i && !cfg_q.lock) begin
            cfg_q.smi_en <= wdata_i[B_SMIEN];
            cfg_q.pol    <= wdata_i[B_POL];
            cfg_q.tim    <= {wdata_i[B_TWR], wdata_i[B_TRD]};
            cfg_q.mode   <= wdata_i[B_MODE];
         end

         // status: hit wins over write-one-to-clear
         if (hit_i)
            cfg_q.stat <= 1'b1;
         else if (wr_en_i && wdata_i[B_STAT])
            cfg_q.stat <= 1'b0;
      end
   end

   assign cfg_o   = cfg_q;
   assign rdata_o = cfg_to_byte(cfg_q);

endmodule

// File: rtl/xcs_cs_gen.sv
module xcs_cs_gen
   import xcs_mode_pkg::*;
(
   input  xcs_cfg_t cfg_i,
   input  logic     sel_i,
   input  logic     write_i,
   input  logic     strobe_i,
   output logic     cs_o
);

   logic [1:0] tim_eff;
   logic       strobe_timed;
   logic       asserted;

   always_comb begin
      tim_eff      = cfg_i.mode ? 2'b00 : cfg_i.tim;
      strobe_timed = write_i ? tim_eff[1] : tim_eff[0];
      asserted     = sel_i && (!strobe_timed || strobe_i);
      cs_o         = cfg_i.pol ? asserted : !asserted;
   end

endmodule

// File: rtl/xcs_line_drv.sv
module xcs_line_drv (
   input  logic mode_i,
   input  logic active_i,
   input  logic write_i,
   input  logic strobe_i,
   output logic wr_line_o,
   output logic rd_line_o
);

   always_comb begin
      if (mode_i) begin
         wr_line_o = !(active_i && write_i);
         rd_line_o = active_i && strobe_i;
      end else begin
         wr_line_o = !(active_i && write_i && strobe_i);
         rd_line_o = !(active_i && !write_i && strobe_i);
      end
   end

endmodule

// File: rtl/xcs_mode_ctrl.sv
module xcs_mode_ctrl
   import xcs_mode_pkg::*;
#(
   parameter int  NUM_CH  = 4,
   parameter bit  SMI_REG = 1'b0,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlock_i,
   input  logic              reg_wr_i,
   input  logic [CH_W-1:0]   reg_sel_i,
   input  logic [MR_W-1:0]   reg_wdata_i,
   output logic [MR_W-1:0]   reg_rdata_o,
   input  logic [CH_W-1:0]   bus_ch_i,
   input  logic              bus_active_i,
   input  logic              bus_write_i,
   input  logic              bus_strobe_i,
   output logic [NUM_CH-1:0] cs_o,
   output logic              wr_line_o,
   output logic              rd_line_o,
   output logic              smi_req_o
);

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("xcs_mode_ctrl: NUM_CH must be 1..16");
   end

   xcs_cfg_t          cfg_arr [NUM_CH];
   logic [MR_W-1:0]   rd_arr  [NUM_CH];
   logic [NUM_CH-1:0] lock_vec;
   logic [NUM_CH-1:0] stat_vec;
   logic [NUM_CH-1:0] en_vec;
   logic [NUM_CH-1:0] pol_vec;
   logic              line_mode;
   logic              smi_raw;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      logic wr_en;
      logic sel;

      assign sel   = bus_active_i && (bus_ch_i == CH_W'(i));
      assign hit   = sel && bus_write_i && bus_strobe_i;
      assign wr_en = reg_wr_i && (reg_sel_i == CH_W'(i));

      xcs_mode_reg u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .unlock_i (unlock_i),
         .wr_en_i  (wr_en),
         .wdata_i  (reg_wdata_i),
         .hit_i    (hit),
         .cfg_o    (cfg_arr[i]),
         .rdata_o  (rd_arr[i])
      );

      xcs_cs_gen u_cs (
         .cfg_i    (cfg_arr[i]),
         .sel_i    (sel),
         .write_i  (bus_write_i),
         .strobe_i (bus_strobe_i),
         .cs_o     (cs_o[i])
      );

      assign lock_vec[i] = cfg_arr[i].lock;
      assign stat_vec[i] = cfg_arr[i].stat;
      assign en_vec[i]   = cfg_arr[i].smi_en;
      assign pol_vec[i]  = cfg_arr[i].pol;
   end

   always_comb begin
      reg_rdata_o = '0;
      line_mode   = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_sel_i == CH_W'(i)) reg_rdata_o = rd_arr[i];
         if (bus_ch_i  == CH_W'(i)) line_mode   = cfg_arr[i].mode;
      end
   end

   xcs_line_drv u_lines (
      .mode_i    (line_mode),
      .active_i  (bus_active_i),
      .write_i   (bus_write_i),
      .strobe_i  (bus_strobe_i),
      .wr_line_o (wr_line_o),
      .rd_line_o (rd_line_o)
   );

   assign smi_raw = |(stat_vec & en_vec);

   if (SMI_REG) begin : g_smi_ff
      logic smi_q;
      always_ff @(posedge clk) begin
         if (!rst_n) smi_q <= 1'b0;
         else        smi_q <= smi_raw;
      end
      assign smi_req_o = smi_q;
   end else begin : g_smi_comb
      assign smi_req_o = smi_raw;
   end

endmodule

// File: rtl/xcs_mode_ctrl_chk.sv
module xcs_mode_ctrl_chk #(
   parameter int NUM_CH  = 4,
   parameter int CH_W    = 2,
   parameter bit SMI_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              unlock_i,
   input logic [CH_W-1:0]   bus_ch_i,
   input logic              bus_active_i,
   input logic              bus_write_i,
   input logic              bus_strobe_i,
   input logic [NUM_CH-1:0] cs_o,
   input logic              wr_line_o,
   input logic              smi_req_o,
   input logic [NUM_CH-1:0] lock_vec,
   input logic [NUM_CH-1:0] stat_vec,
   input logic [NUM_CH-1:0] pol_vec
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_vec[i] && !unlock_i) |=> lock_vec[i]);

      p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_active_i && bus_write_i && bus_strobe_i && bus_ch_i == CH_W'(i))
         |=> stat_vec[i]);
   end

   p_unlock_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_i |=> (lock_vec == '0));

   if (SMI_REG) begin : g_smi_ff
      p_smi_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
         smi_req_o |-> $past(|stat_vec));
   end else begin : g_smi_comb
      p_smi_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
         smi_req_o |-> (|stat_vec));
   end

   p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_active_i |-> (cs_o == ~pol_vec));

   p_single_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_o ^ ~pol_vec));

   p_wr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_active_i |-> wr_line_o);

endmodule

bind xcs_mode_ctrl xcs_mode_ctrl_chk #(
   .NUM_CH  (NUM_CH),
   .CH_W    (CH_W),
   .SMI_REG (SMI_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .unlock_i     (unlock_i),
   .bus_ch_i     (bus_ch_i),
   .bus_active_i (bus_active_i),
   .bus_write_i  (bus_write_i),
   .bus_strobe_i (bus_strobe_i),
   .cs_o         (cs_o),
   .wr_line_o    (wr_line_o),
   .smi_req_o    (smi_req_o),
   .lock_vec     (lock_vec),
   .stat_vec     (stat_vec),
   .pol_vec      (pol_vec)
);

// File: tb/xcs_mode_ctrl_bench.sv
module xcs_mode_ctrl_bench;

   localparam int NCH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       unlock = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] bus_ch = '0;
   logic       bus_act = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_stb = 1'b0;
   logic [3:0] cs;
   logic       wr_line;
   logic       rd_line;
   logic       smi;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   xcs_mode_ctrl #(.NUM_CH(NCH), .SMI_REG(1'b0)) u_xcs_mode_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .unlock_i     (unlock),
      .reg_wr_i     (reg_wr),
      .reg_sel_i    (reg_sel),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .bus_ch_i     (bus_ch),
      .bus_active_i (bus_act),
      .bus_write_i  (bus_wr),
      .bus_strobe_i (bus_stb),
      .cs_o         (cs),
      .wr_line_o    (wr_line),
      .rd_line_o    (rd_line),
      .smi_req_o    (smi)
   );

   typedef struct packed {
      logic [1:0] ch;
      logic [7:0] cfg;
      logic       act;
      logic       wr;
      logic       stb;
      logic       exp_as;
      logic       exp_wr;
      logic       exp_rd;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R8 R10 read, no strobe
      '{2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R10 strobed read
      '{2'd1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R10 strobed write
      '{2'd1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R10 write, no strobe
      '{2'd2, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 read strobe-timed
      '{2'd2, 8'h04, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R8
      '{2'd2, 8'h04, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R8 write stays normal
      '{2'd3, 8'h08, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 write strobe-timed
      '{2'd3, 8'h08, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R8
      '{2'd3, 8'h08, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R8 read stays normal
      '{2'd0, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 both timed, read
      '{2'd0, 8'h0C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 both timed, write
      '{2'd1, 8'h0E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R9 R11 read
      '{2'd1, 8'h0E, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R9 R11 write
      '{2'd1, 8'h0E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R11 write strobed
      '{2'd1, 8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R11 read strobed
      '{2'd2, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R7 active-high select
      '{2'd2, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 idle low
      '{2'd3, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 R11 idle lines mode 1
      '{2'd0, 8'h14, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}   // R7 R8 pol high, timed
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_check(input string tag, input logic [1:0] sel, input logic [7:0] exp);
      reg_sel = sel;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic bus_hit(input logic [1:0] ch);
      @(negedge clk);
      bus_ch = ch; bus_act = 1'b1; bus_wr = 1'b1; bus_stb = 1'b1;
      @(negedge clk);
      bus_act = 1'b0; bus_wr = 1'b0; bus_stb = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int c = 0; c < NCH; c++) read_check("R1 readback", 2'(c), 8'h00);
      check("R1 cs", {4'h0, cs}, 8'h0F);
      check("R1 wr_line", {7'h0, wr_line}, 8'h01);
      check("R1 rd_line", {7'h0, rd_line}, 8'h01);
      check("R1 smi", {7'h0, smi}, 8'h00);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         logic [3:0] exp_cs;
         write_reg(VECS[v].ch, VECS[v].cfg);
         bus_ch = VECS[v].ch; bus_act = VECS[v].act;
         bus_wr = VECS[v].wr; bus_stb = VECS[v].stb;
         #1;
         exp_cs = 4'hF;
         exp_cs[VECS[v].ch] = VECS[v].cfg[4] ? VECS[v].exp_as : !VECS[v].exp_as;
         check("R7/R8/R9 cs", {4'h0, cs}, {4'h0, exp_cs});
         check("R10/R11 wr_line", {7'h0, wr_line}, {7'h0, VECS[v].exp_wr});
         check("R10/R11 rd_line", {7'h0, rd_line}, {7'h0, VECS[v].exp_rd});
         @(negedge clk);
         bus_act = 1'b0; bus_wr = 1'b0; bus_stb = 1'b0;
         write_reg(VECS[v].ch, 8'h40);
      end

      // R2 field storage, bit 0 reserved
      write_reg(2'd1, 8'h3F);
      read_check("R2 store", 2'd1, 8'h3E);
      write_reg(2'd1, 8'h00);
      read_check("R2 clear", 2'd1, 8'h00);

      // R3 writing 0 to lock leaves the channel writable
      write_reg(2'd0, 8'h10);
      write_reg(2'd0, 8'h00);
      read_check("R3 no lock", 2'd0, 8'h00);

      // R3 lock freezes configuration
      write_reg(2'd2, 8'h90);
      read_check("R3 locked", 2'd2, 8'h90);
      write_reg(2'd2, 8'h00);
      read_check("R3 write ignored", 2'd2, 8'h90);
      write_reg(2'd2, 8'h02);
      read_check("R3 mode held", 2'd2, 8'h90);
      #1;
      check("R3 pol held cs", {4'h0, cs}, 8'h0B);

      // R5 flag on locked channel, clear exempt from lock
      bus_hit(2'd2);
      read_check("R5 set locked", 2'd2, 8'hD0);
      write_reg(2'd2, 8'h40);
      read_check("R5 clear locked", 2'd2, 8'h90);

      // R6 interrupt request
      write_reg(2'd3, 8'h20);
      #1;
      check("R6 smi idle", {7'h0, smi}, 8'h00);
      bus_hit(2'd3);
      #1;
      check("R6 smi raised", {7'h0, smi}, 8'h01);
      read_check("R5 set", 2'd3, 8'h60);
      write_reg(2'd3, 8'h60);
      #1;
      check("R6 smi cleared", {7'h0, smi}, 8'h00);
      read_check("R5 cleared", 2'd3, 8'h20);

      // R5 same-cycle set and clear: set wins
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h60;
      bus_ch = 2'd3; bus_act = 1'b1; bus_wr = 1'b1; bus_stb = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; bus_act = 1'b0; bus_wr = 1'b0; bus_stb = 1'b0;
      read_check("R5 set priority", 2'd3, 8'h60);
      #1;
      check("R6 smi held", {7'h0, smi}, 8'h01);

      // R4 unlock pulse
      @(negedge clk);
      unlock = 1'b1;
      @(negedge clk);
      unlock = 1'b0;
      read_check("R4 unlocked", 2'd2, 8'h10);
      write_reg(2'd2, 8'h00);
      read_check("R4 writable", 2'd2, 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule